// File: doc/BRIEF.md
# Age-Ordered Redirect Filter

In the back end of an out-of-order core several units can ask for a redirect in the same cycle. These units include branch resolution and the exception detectors. This block takes up to `NUM_SRC` such requests per cycle. Each request carries:

- the sequence number of the instruction that caused it,
- a corrected target address,
- a taken flag,
- a mispredict flag.

The block decides which request, if any, becomes the single squash that the earlier pipeline stages see.

The block keeps a register holding the sequence number of the youngest instruction still considered valid in flight.

- Each new allocation sets this register to the allocated instruction's number.
- Each broadcast squash overwrites it with the squashing instruction's number.

A request is eligible only if its instruction is not younger than that value. A younger instruction has already been removed by an earlier squash. Among the eligible requests, the oldest one wins. The winner is broadcast one cycle later as a single-cycle pulse. The pulse carries the squash-until sequence number and the redirect details.

Two free-running counters record the squashes. One counts every broadcast squash. The other counts only the squashes flagged as branch mispredicts. Sequence numbers wrap around, so every age comparison uses the sign of the modular difference.

Top module: `redirect_filter`

## Requirements
- R1: After synchronous reset, `sq_valid` is 0, both counters are 0, and the youngest-valid value is 0. With that value, a request with sequence 0 is accepted and a request with sequence 1 is dropped.
- R2: When several eligible requests arrive in one cycle, the one with the oldest sequence number is broadcast.
- R3: A request whose sequence number is younger than the youngest-valid value is discarded without effect. A request whose sequence number is equal to that value is accepted.
- R4: A broadcast squash sets the youngest-valid value to the winning sequence number. Later requests younger than it are then dropped.
- R5: An allocation with no accepted request in the same cycle sets the youngest-valid value to `alloc_seq`. When a request is accepted in the same cycle, the squash value takes priority over the allocation.
- R6: A request accepted in cycle t makes `sq_valid` high in cycle t+1 only. In that cycle, `sq_seq`, `sq_target`, `sq_taken` and `sq_mispred` equal the winner's fields.
- R7: `squash_cnt` increases by exactly one for each cycle in which `sq_valid` is high, and holds otherwise.
- R8: `mispred_cnt` increases by one only in cycles where `sq_valid` and `sq_mispred` are both high.
- R9: Age is the sign of the 16-bit difference `a - b`: negative means older. This keeps ordering correct across the 0xFFFF to 0x0000 wrap.
- R10: When eligible requests carry equal sequence numbers, the lowest source index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | A new instruction is allocated this cycle |
| alloc_seq | input | 16 | Sequence number of the allocated instruction |
| req_valid | input | NUM_SRC | One bit per request source |
| req_seq | input | NUM_SRC*16 | Source i's sequence number in bits [16i+15:16i] |
| req_target | input | NUM_SRC*32 | Source i's corrected target in bits [32i+31:32i] |
| req_taken | input | NUM_SRC | Branch taken flag per source |
| req_mispred | input | NUM_SRC | Branch mispredict flag per source |
| sq_valid | output | 1 | One-cycle squash broadcast |
| sq_seq | output | 16 | Squash-until sequence number |
| sq_target | output | 32 | Redirect target |
| sq_taken | output | 1 | Taken flag of the winner |
| sq_mispred | output | 1 | Winner was a branch mispredict |
| squash_cnt | output | CNT_W | Count of broadcast squashes |
| mispred_cnt | output | CNT_W | Count of mispredict-caused squashes |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:

- **Equal-to-youngest request.** It must be accepted; an off-by-one comparison would drop it.
- **Request younger than a squash just broadcast.** It must vanish; a filter that compared against the stale value would emit a second squash.
- **Allocation and accepted request in the same cycle.** A design that let the allocation win would then accept requests it should drop.
- **Ties and wraparound.** Equal sequence numbers from two sources, and pairs that straddle the 16-bit wrap, are also driven. An unsigned compare would pick the wrong winner, and a poor tie rule would report the wrong target.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int SEQ_W  = 16;
    localparam int ADDR_W = 32;

    typedef logic [SEQ_W-1:0]  seq_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        seq_t  seq;
        addr_t target;
        logic  taken;
        logic  mispred;
    } redirect_t;

    // True when a is strictly older than b (modular signed difference).
    function automatic logic seq_older(input seq_t a, input seq_t b);
        seq_t d;
        d = a - b;
        return d[SEQ_W-1];
    endfunction

    // True when a is older than or equal to b.
    function automatic logic seq_not_younger(input seq_t a, input seq_t b);
        return seq_older(a, b) || (a == b);
    endfunction

endpackage

// File: rtl/rf_src_qualify.sv
module rf_src_qualify
    import rf_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic      [NUM_SRC-1:0] valid_in,
    input  redirect_t               req_in [NUM_SRC],
    input  seq_t                    youngest,
    output logic      [NUM_SRC-1:0] eligible
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_qual
        assign eligible[g] = valid_in[g] && seq_not_younger(req_in[g].seq, youngest);
    end

endmodule

// File: rtl/rf_oldest_pick.sv
module rf_oldest_pick
    import rf_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic      [NUM_SRC-1:0] eligible,
    input  redirect_t               req_in [NUM_SRC],
    output logic                    win_valid,
    output redirect_t               win
);

    always_comb begin
        win_valid = 1'b0;
        win       = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            // Strict comparison keeps the lowest index on equal sequence numbers.
            if (eligible[i] && (!win_valid || seq_older(req_in[i].seq, win.seq))) begin
                win_valid = 1'b1;
                win       = req_in[i];
            end
        end
    end

endmodule

// File: rtl/rf_track.sv
module rf_track
    import rf_pkg::*;
#(
    parameter int   CNT_W     = 16,
    parameter seq_t RESET_SEQ = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_valid,
    input  seq_t             alloc_seq,
    input  logic             win_valid,
    input  seq_t             win_seq,
    input  logic             win_mispred,
    output seq_t             youngest,
    output logic [CNT_W-1:0] squash_cnt,
    output logic [CNT_W-1:0] mispred_cnt
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            youngest    <= RESET_SEQ;
            squash_cnt  <= '0;
            mispred_cnt <= '0;
        end else begin
            if (win_valid) begin
                youngest   <= win_seq;
                squash_cnt <= squash_cnt + CNT_ONE;
                if (win_mispred) begin
                    mispred_cnt <= mispred_cnt + CNT_ONE;
                end
            end else if (alloc_valid) begin
                youngest <= alloc_seq;
            end
        end
    end

endmodule

// File: rtl/redirect_filter.sv
module redirect_filter
    import rf_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int CNT_W   = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      alloc_valid,
    input  logic [SEQ_W-1:0]          alloc_seq,
    input  logic [NUM_SRC-1:0]        req_valid,
    input  logic [NUM_SRC*SEQ_W-1:0]  req_seq,
    input  logic [NUM_SRC*ADDR_W-1:0] req_target,
    input  logic [NUM_SRC-1:0]        req_taken,
    input  logic [NUM_SRC-1:0]        req_mispred,
    output logic                      sq_valid,
    output logic [SEQ_W-1:0]          sq_seq,
    output logic [ADDR_W-1:0]         sq_target,
    output logic                      sq_taken,
    output logic                      sq_mispred,
    output logic [CNT_W-1:0]          squash_cnt,
    output logic [CNT_W-1:0]          mispred_cnt
);

    redirect_t            req_arr [NUM_SRC];
    logic [NUM_SRC-1:0]   eligible;
    logic                 win_valid;
    redirect_t            win;
    seq_t                 youngest_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
        assign req_arr[g].seq     = req_seq[g*SEQ_W +: SEQ_W];
        assign req_arr[g].target  = req_target[g*ADDR_W +: ADDR_W];
        assign req_arr[g].taken   = req_taken[g];
        assign req_arr[g].mispred = req_mispred[g];
    end

    rf_src_qualify #(.NUM_SRC(NUM_SRC)) qual_i (
        .valid_in (req_valid),
        .req_in   (req_arr),
        .youngest (youngest_q),
        .eligible (eligible)
    );

    rf_oldest_pick #(.NUM_SRC(NUM_SRC)) pick_i (
        .eligible  (eligible),
        .req_in    (req_arr),
        .win_valid (win_valid),
        .win       (win)
    );

    rf_track #(.CNT_W(CNT_W)) track_i (
        .clk         (clk),
        .rst         (rst),
        .alloc_valid (alloc_valid),
        .alloc_seq   (alloc_seq),
        .win_valid   (win_valid),
        .win_seq     (win.seq),
        .win_mispred (win.mispred),
        .youngest    (youngest_q),
        .squash_cnt  (squash_cnt),
        .mispred_cnt (mispred_cnt)
    );

    redirect_t bcast_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_valid <= 1'b0;
            bcast_q  <= '0;
        end else begin
            sq_valid <= win_valid;
            if (win_valid) begin
                bcast_q <= win;
            end
        end
    end

    assign sq_seq     = bcast_q.seq;
    assign sq_target  = bcast_q.target;
    assign sq_taken   = bcast_q.taken;
    assign sq_mispred = bcast_q.mispred;

endmodule

// File: rtl/redirect_filter_chk.sv
module redirect_filter_chk
    import rf_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] req_valid,
    input logic               sq_valid,
    input logic [SEQ_W-1:0]   sq_seq,
    input logic               sq_mispred,
    input logic [CNT_W-1:0]   squash_cnt,
    input logic [CNT_W-1:0]   mispred_cnt,
    input logic [SEQ_W-1:0]   youngest_q
);

    // R6: a broadcast needs a request in the previous cycle
    assert_bcast_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
        sq_valid |-> $past(|req_valid));

    // R3: the broadcast sequence was not younger than the youngest-valid value it was checked against
    assert_not_younger_R3: assert property (@(posedge clk) disable iff (rst)
        sq_valid |-> seq_not_younger(sq_seq, $past(youngest_q)));

    // R4: tracking register follows the broadcast sequence
    assert_youngest_follows_R4: assert property (@(posedge clk) disable iff (rst)
        sq_valid |-> (youngest_q == sq_seq));

    // R7: squash counter steps with each broadcast
    assert_squash_step_R7: assert property (@(posedge clk) disable iff (rst)
        sq_valid |-> (squash_cnt == $past(squash_cnt) + CNT_W'(1)));

    // R7: squash counter holds without a broadcast
    assert_squash_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !sq_valid |-> $stable(squash_cnt));

    // R8: mispredict counter moves only on a mispredict broadcast
    assert_mispred_only_R8: assert property (@(posedge clk) disable iff (rst)
        (mispred_cnt != $past(mispred_cnt)) |-> (sq_valid && sq_mispred));

endmodule

bind redirect_filter redirect_filter_chk #(
    .NUM_SRC (NUM_SRC),
    .CNT_W   (CNT_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .sq_valid    (sq_valid),
    .sq_seq      (sq_seq),
    .sq_mispred  (sq_mispred),
    .squash_cnt  (squash_cnt),
    .mispred_cnt (mispred_cnt),
    .youngest_q  (youngest_q)
);

// File: tb/redirect_filter_tb.sv
module redirect_filter_tb_top;

    localparam int N     = 4;
    localparam int SW    = 16;
    localparam int AW    = 32;
    localparam int CW    = 16;
    localparam int NVEC  = 14;

    typedef struct packed {
        logic          alloc_v;
        logic [15:0]   alloc_seq;
        logic [3:0]    rmask;
        logic [15:0]   s0;
        logic [15:0]   s1;
        logic [15:0]   s2;
        logic [15:0]   s3;
        logic [3:0]    mmask;
        logic          exp_v;
        logic [1:0]    exp_src;
        logic [15:0]   exp_seq;
    } vec_t;

    localparam vec_t VECS [0:NVEC-1] = '{
        '{1'b1, 16'd10,     4'b0000, 16'd0,      16'd0,      16'd0,      16'd0,      4'b0000, 1'b0, 2'd0, 16'd0},
        '{1'b1, 16'd20,     4'b0000, 16'd0,      16'd0,      16'd0,      16'd0,      4'b0000, 1'b0, 2'd0, 16'd0},
        '{1'b0, 16'd0,      4'b0111, 16'd15,     16'd12,     16'd25,     16'd0,      4'b0001, 1'b1, 2'd1, 16'd12},
        '{1'b0, 16'd0,      4'b1001, 16'd15,     16'd0,      16'd0,      16'd12,     4'b1000, 1'b1, 2'd3, 16'd12},
        '{1'b1, 16'd30,     4'b0100, 16'd0,      16'd0,      16'd11,     16'd0,      4'b0100, 1'b1, 2'd2, 16'd11},
        '{1'b0, 16'd0,      4'b0001, 16'd12,     16'd0,      16'd0,      16'd0,      4'b0000, 1'b0, 2'd0, 16'd0},
        '{1'b1, 16'd100,    4'b0000, 16'd0,      16'd0,      16'd0,      16'd0,      4'b0000, 1'b0, 2'd0, 16'd0},
        '{1'b0, 16'd0,      4'b0110, 16'd0,      16'd50,     16'd50,     16'd0,      4'b0100, 1'b1, 2'd1, 16'd50},
        '{1'b1, 16'hFFF0,   4'b0000, 16'd0,      16'd0,      16'd0,      16'd0,      4'b0000, 1'b0, 2'd0, 16'd0},
        '{1'b1, 16'h0005,   4'b0000, 16'd0,      16'd0,      16'd0,      16'd0,      4'b0000, 1'b0, 2'd0, 16'd0},
        '{1'b0, 16'd0,      4'b0111, 16'hFFF8,   16'h0003,   16'h0006,   16'd0,      4'b0001, 1'b1, 2'd0, 16'hFFF8},
        '{1'b0, 16'd0,      4'b0110, 16'd0,      16'h0002,   16'hFFF7,   16'd0,      4'b0000, 1'b1, 2'd2, 16'hFFF7},
        '{1'b0, 16'd0,      4'b1111, 16'hFFF0,   16'hFFF1,   16'hFFEE,   16'hFFF7,   4'b0100, 1'b1, 2'd2, 16'hFFEE},
        '{1'b0, 16'd0,      4'b0000, 16'd0,      16'd0,      16'd0,      16'd0,      4'b0000, 1'b0, 2'd0, 16'd0}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           alloc_valid = 1'b0;
    logic [SW-1:0]  alloc_seq = '0;
    logic [N-1:0]   req_valid = '0;
    logic [N*SW-1:0] req_seq = '0;
    logic [N*AW-1:0] req_target = '0;
    logic [N-1:0]   req_taken = '0;
    logic [N-1:0]   req_mispred = '0;
    logic           sq_valid;
    logic [SW-1:0]  sq_seq;
    logic [AW-1:0]  sq_target;
    logic           sq_taken;
    logic           sq_mispred;
    logic [CW-1:0]  squash_cnt;
    logic [CW-1:0]  mispred_cnt;

    int checks = 0;
    int errors = 0;
    int exp_sq = 0;
    int exp_mis = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    redirect_filter #(.NUM_SRC(N), .CNT_W(CW)) dut_i (
        .clk, .rst, .alloc_valid, .alloc_seq, .req_valid, .req_seq,
        .req_target, .req_taken, .req_mispred, .sq_valid, .sq_seq,
        .sq_target, .sq_taken, .sq_mispred, .squash_cnt, .mispred_cnt
    );

    function automatic logic [AW-1:0] tgt_of(input int src, input logic [SW-1:0] s);
        return {8'hA5, 6'b0, 2'(src), s};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_req(input int src, input logic [SW-1:0] s, input logic mis);
        req_valid[src] = 1'b1;
        req_seq[src*SW +: SW] = s;
        req_target[src*AW +: AW] = tgt_of(src, s);
        req_taken[src] = s[0];
        req_mispred[src] = mis;
    endtask

    task automatic clear_in();
        alloc_valid = 1'b0;
        alloc_seq = '0;
        req_valid = '0;
        req_seq = '0;
        req_target = '0;
        req_taken = '0;
        req_mispred = '0;
    endtask

    // One cycle: inputs already driven after a negedge; sample just past the next posedge.
    task automatic step_check(input logic ev, input int src, input logic [SW-1:0] s, input logic mis, input string tag);
        @(posedge clk);
        #1;
        chk({tag, " R3/R4 valid"}, 64'(sq_valid), 64'(ev));
        if (ev) begin
            exp_sq++;
            if (mis) exp_mis++;
            chk({tag, " R2/R9/R10 seq"}, 64'(sq_seq), 64'(s));
            chk({tag, " R6 target"}, 64'(sq_target), 64'(tgt_of(src, s)));
            chk({tag, " R6 taken"}, 64'(sq_taken), 64'(s[0]));
            chk({tag, " R6 mispred"}, 64'(sq_mispred), 64'(mis));
        end
        chk({tag, " R7 squash_cnt"}, 64'(squash_cnt), 64'(exp_sq));
        chk({tag, " R8 mispred_cnt"}, 64'(mispred_cnt), 64'(exp_mis));
        @(negedge clk);
        clear_in();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        #1;
        chk("R1 sq_valid after reset", 64'(sq_valid), 64'd0);
        chk("R1 squash_cnt after reset", 64'(squash_cnt), 64'd0);
        chk("R1 mispred_cnt after reset", 64'(mispred_cnt), 64'd0);

        for (int k = 0; k < NVEC; k++) begin
            vec_t v;
            v = VECS[k];
            clear_in();
            alloc_valid = v.alloc_v;
            alloc_seq = v.alloc_seq;
            if (v.rmask[0]) drive_req(0, v.s0, v.mmask[0]);
            if (v.rmask[1]) drive_req(1, v.s1, v.mmask[1]);
            if (v.rmask[2]) drive_req(2, v.s2, v.mmask[2]);
            if (v.rmask[3]) drive_req(3, v.s3, v.mmask[3]);
            step_check(v.exp_v, int'(v.exp_src), v.exp_seq, v.mmask[v.exp_src], $sformatf("vec%0d", k));
        end

        // R1: reset mid-run clears counters, youngest-valid back to 0
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        exp_sq = 0;
        exp_mis = 0;
        #1;
        chk("R1 squash_cnt cleared", 64'(squash_cnt), 64'd0);
        chk("R1 mispred_cnt cleared", 64'(mispred_cnt), 64'd0);
        @(negedge clk);
        drive_req(0, 16'd1, 1'b0);
        step_check(1'b0, 0, 16'd0, 1'b0, "R1 seq1 dropped");
        drive_req(2, 16'd0, 1'b1);
        step_check(1'b1, 2, 16'd0, 1'b1, "R1 seq0 accepted");
        // R6: the pulse lasts one cycle
        step_check(1'b0, 0, 16'd0, 1'b0, "R6 pulse ends");

        // R5: allocation moves youngest-valid
        alloc_valid = 1'b1; alloc_seq = 16'd40;
        step_check(1'b0, 0, 16'd0, 1'b0, "R5 alloc 40");
        // R5: squash has priority over same-cycle allocation
        alloc_valid = 1'b1; alloc_seq = 16'd60;
        drive_req(1, 16'd30, 1'b0);
        step_check(1'b1, 1, 16'd30, 1'b0, "R5 alloc+squash");
        drive_req(0, 16'd35, 1'b1);
        step_check(1'b0, 0, 16'd0, 1'b0, "R5 35 dropped");
        drive_req(3, 16'd30, 1'b1);
        step_check(1'b1, 3, 16'd30, 1'b1, "R5 30 accepted");
        step_check(1'b0, 0, 16'd0, 1'b0, "R6 idle");

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule